// File: doc/BRIEF.md
# Indirect Memory Access Controller

This block lets a host reach several internal RAMs one word at a time through a narrow staging path. The host first writes a control byte. The byte picks the target memory, the direction, the addressing mode and the starting word-select slice. The host then issues transfer commands. Each transfer with the buffer-load code moves the 32-bit staging value toward the selected RAM, or fetches one 32-bit slice of the addressed RAM word back into a read register.

Coefficient words are 72 bits wide, so they are built from three 32-bit slices under a word-select counter. A RAM write fires only after the last slice has arrived. The I and Q coefficient RAMs can be written separately or both together. The 8-bit map RAM is written on every transfer. The 32-bit FIFO RAM can only be read. The address comes either from the host on every transfer or from an internal counter. The counter advances after each complete word and wraps at the depth of the selected memory. The RAMs sit outside the block and return read data combinationally for the address shown on `rd_addr`.

Top module: `imc_top`

## Requirements
- R1: After reset no write strobe is active, `rd_data` is 0, the word-select counter is 0, and manual addressing is in force, so `rd_addr` equals `host_addr`.
- R2: Writing a coefficient target takes three transfers: word-select 0 fills bits 31:0, word-select 1 fills bits 63:32, and bits 7:0 of the third staging value fill bits 71:64. Only the third transfer raises a write strobe, for exactly one cycle, and `coef_wdata` then carries the full 72-bit word.
- R3: Control byte bits 4:2 select the target. Code 001 writes only the I RAM, 010 writes only the Q RAM, and 011 writes both together with the same data and address.
- R4: With target 100 (map RAM) in write mode, every transfer raises `map_we` for one cycle, with bits 7:0 of the staging value on `map_wdata`.
- R5: With control bit 6 at 0, the write address and `rd_addr` equal `host_addr`.
- R6: With control bit 6 at 1, the internal address starts at 0 and steps by one after each complete word. It wraps to 0 after 63 for coefficient targets, and after 255 for the map and FIFO targets.
- R7: A control write whose target field differs from the current one resets the internal address to 0. A control write with the same target keeps it.
- R8: In write mode, a transfer aimed at the FIFO (101) or at an unused code (000, 110, 111) raises no write strobe and leaves the internal address unchanged.
- R9: Reading a coefficient target (control bit 5 at 1) returns bits 31:0, 63:32 and then zero-extended bits 71:64 of the addressed word on successive transfers, and steps the address after the third. Code 011 reads the I RAM.
- R10: Reading the map RAM returns the zero-extended byte, and reading the FIFO returns the full 32-bit word. Each such transfer steps the address.
- R11: A transfer whose code is not 0x0F has no effect: no strobe, no address change, and `rd_data` is held.
- R12: A control write loads the word-select counter from bits 1:0. Writing 00 in the middle of a word restarts assembly at slice 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads the memory control byte |
| cfg_data | input | 8 | Control byte: bit 6 auto-increment, bit 5 read, bits 4:2 target, bits 1:0 word select |
| xfer_stb | input | 1 | Transfer command strobe |
| xfer_code | input | 8 | Transfer command code; only 0x0F acts here |
| stage_data | input | 32 | Staging register value |
| host_addr | input | AW (8) | Host-supplied memory address |
| coef_i_we | output | 1 | I coefficient RAM write strobe |
| coef_q_we | output | 1 | Q coefficient RAM write strobe |
| coef_wdata | output | 72 | Coefficient write word |
| map_we | output | 1 | Map RAM write strobe |
| map_wdata | output | 8 | Map RAM write byte |
| wr_addr | output | AW (8) | Write address that goes with the strobes |
| rd_addr | output | AW (8) | Current effective address for the read ports |
| coef_i_rdata | input | 72 | I RAM read word at `rd_addr` |
| coef_q_rdata | input | 72 | Q RAM read word at `rd_addr` |
| map_rdata | input | 8 | Map RAM read byte at `rd_addr` |
| fifo_rdata | input | 32 | FIFO RAM read word at `rd_addr` |
| rd_data | output | 32 | Last slice fetched by a read transfer |

## Verification
The bench uses the default parameters: a 64-deep, 72-bit coefficient RAM, a 256-deep map RAM and a 256-deep FIFO. With these sizes both address wrap points can be reached in a short run. A full pass of 192 coefficient slices reaches the wrap after word 63, and 256 map writes reach the wrap after 255. The bench models the RAM read ports as fixed functions of `rd_addr`. Every fetched slice therefore has a known expected value, including the zero-extended top slice.

// File: rtl/imc_pkg.sv
package imc_pkg;

    typedef enum logic [2:0] {
        TGT_NONE    = 3'd0,
        TGT_COEF_I  = 3'd1,
        TGT_COEF_Q  = 3'd2,
        TGT_COEF_IQ = 3'd3,
        TGT_MAP     = 3'd4,
        TGT_FIFO    = 3'd5,
        TGT_RSV6    = 3'd6,
        TGT_RSV7    = 3'd7
    } tgt_e;

    typedef struct packed {
        logic auto_inc;
        logic rd_dir;
        tgt_e tgt;
    } ctrl_t;

    function automatic logic is_coef(input tgt_e t);
        return (t == TGT_COEF_I) || (t == TGT_COEF_Q) || (t == TGT_COEF_IQ);
    endfunction

endpackage

// File: rtl/imc_addr_gen.sv
module imc_addr_gen #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [AW-1:0] last,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clear) begin
            addr_d = '0;
        end else if (step) begin
            addr_d = (addr_q >= last) ? '0 : addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    // R6: the generated address never leaves the selected memory
    assert_addr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= last);

    // R7: a target change lands the address at zero
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> addr_q == '0);

endmodule

// File: rtl/imc_wide_buf.sv
module imc_wide_buf #(
    parameter int STAGE_W = 32,
    parameter int NSLICE  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic [1:0]                        ws,
    input  logic [STAGE_W-1:0]                stage,
    output logic [(NSLICE-1)*STAGE_W-1:0]     held_o
);
    localparam int NHELD = NSLICE - 1;

    logic [NHELD-1:0][STAGE_W-1:0] held_d, held_q;

    for (genvar k = 0; k < NHELD; k++) begin : g_slice
        always_comb begin
            held_d[k] = held_q[k];
            if (load && (ws == 2'(k))) held_d[k] = stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign held_o = held_q;

    // R2: a held slice only changes on a load
    assert_slice_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held_q));

endmodule

// File: rtl/imc_top.sv
module imc_top
    import imc_pkg::*;
#(
    parameter int          STAGE_W    = 32,
    parameter int          COEF_W     = 72,
    parameter int          COEF_DEPTH = 64,
    parameter int          MAP_W      = 8,
    parameter int          MAP_DEPTH  = 256,
    parameter int          FIFO_DEPTH = 256,
    parameter logic [7:0]  LOAD_CODE  = 8'h0F,
    localparam int MAXD = (COEF_DEPTH > MAP_DEPTH)
                          ? ((COEF_DEPTH > FIFO_DEPTH) ? COEF_DEPTH : FIFO_DEPTH)
                          : ((MAP_DEPTH > FIFO_DEPTH) ? MAP_DEPTH : FIFO_DEPTH),
    localparam int AW = $clog2(MAXD)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_data,
    input  logic               xfer_stb,
    input  logic [7:0]         xfer_code,
    input  logic [STAGE_W-1:0] stage_data,
    input  logic [AW-1:0]      host_addr,
    output logic               coef_i_we,
    output logic               coef_q_we,
    output logic [COEF_W-1:0]  coef_wdata,
    output logic               map_we,
    output logic [MAP_W-1:0]   map_wdata,
    output logic [AW-1:0]      wr_addr,
    output logic [AW-1:0]      rd_addr,
    input  logic [COEF_W-1:0]  coef_i_rdata,
    input  logic [COEF_W-1:0]  coef_q_rdata,
    input  logic [MAP_W-1:0]   map_rdata,
    input  logic [STAGE_W-1:0] fifo_rdata,
    output logic [STAGE_W-1:0] rd_data
);
    localparam int         NSLICE  = (COEF_W + STAGE_W - 1) / STAGE_W;
    localparam logic [1:0] LAST_WS = 2'(NSLICE - 1);

    typedef struct packed {
        ctrl_t              ctrl;
        logic [1:0]         ws;
        logic               i_we;
        logic               q_we;
        logic               m_we;
        logic [COEF_W-1:0]  cwd;
        logic [MAP_W-1:0]   mwd;
        logic [AW-1:0]      waddr;
        logic [STAGE_W-1:0] rdat;
    } st_t;

    st_t s_d, s_q;

    logic                           go, wide, last_slice, step, clear, buf_load;
    logic [AW-1:0]                  gen_addr, eff_addr, depth_last;
    logic [(NSLICE-1)*STAGE_W-1:0]  held;
    logic [NSLICE*STAGE_W-1:0]      full_word;
    logic [4*STAGE_W-1:0]           rpad;

    assign go         = xfer_stb && (xfer_code == LOAD_CODE) && !cfg_we;
    assign wide       = is_coef(s_q.ctrl.tgt);
    assign last_slice = (s_q.ws >= LAST_WS);
    assign eff_addr   = s_q.ctrl.auto_inc ? gen_addr : host_addr;
    assign clear      = cfg_we && (cfg_data[4:2] != s_q.ctrl.tgt);
    assign buf_load   = go && wide && !s_q.ctrl.rd_dir;
    assign full_word  = {stage_data, held};

    always_comb begin
        case (s_q.ctrl.tgt)
            TGT_COEF_I, TGT_COEF_Q, TGT_COEF_IQ: depth_last = AW'(COEF_DEPTH - 1);
            TGT_MAP:                             depth_last = AW'(MAP_DEPTH - 1);
            TGT_FIFO:                            depth_last = AW'(FIFO_DEPTH - 1);
            default:                             depth_last = '0;
        endcase
    end

    always_comb begin
        rpad = '0;
        rpad[COEF_W-1:0] = (s_q.ctrl.tgt == TGT_COEF_Q) ? coef_q_rdata : coef_i_rdata;
    end

    always_comb begin
        s_d      = s_q;
        s_d.i_we = 1'b0;
        s_d.q_we = 1'b0;
        s_d.m_we = 1'b0;
        step     = 1'b0;
        if (cfg_we) begin
            s_d.ctrl.auto_inc = cfg_data[6];
            s_d.ctrl.rd_dir   = cfg_data[5];
            s_d.ctrl.tgt      = tgt_e'(cfg_data[4:2]);
            s_d.ws            = cfg_data[1:0];
        end else if (go) begin
            if (wide) begin
                if (s_q.ctrl.rd_dir) begin
                    s_d.rdat = rpad[32'(s_q.ws) * STAGE_W +: STAGE_W];
                end
                if (last_slice) begin
                    if (!s_q.ctrl.rd_dir) begin
                        s_d.i_we  = s_q.ctrl.tgt[0];
                        s_d.q_we  = s_q.ctrl.tgt[1];
                        s_d.cwd   = full_word[COEF_W-1:0];
                        s_d.waddr = eff_addr;
                    end
                    s_d.ws = 2'd0;
                    step   = 1'b1;
                end else begin
                    s_d.ws = s_q.ws + 2'd1;
                end
            end else if (s_q.ctrl.tgt == TGT_MAP) begin
                if (s_q.ctrl.rd_dir) begin
                    s_d.rdat = STAGE_W'(map_rdata);
                end else begin
                    s_d.m_we  = 1'b1;
                    s_d.mwd   = stage_data[MAP_W-1:0];
                    s_d.waddr = eff_addr;
                end
                step = 1'b1;
            end else if ((s_q.ctrl.tgt == TGT_FIFO) && s_q.ctrl.rd_dir) begin
                s_d.rdat = fifo_rdata;
                step     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    imc_addr_gen #(.AW(AW)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .step   (step && s_q.ctrl.auto_inc),
        .last   (depth_last),
        .addr_o (gen_addr)
    );

    imc_wide_buf #(.STAGE_W(STAGE_W), .NSLICE(NSLICE)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (buf_load),
        .ws     (s_q.ws),
        .stage  (stage_data),
        .held_o (held)
    );

    assign coef_i_we  = s_q.i_we;
    assign coef_q_we  = s_q.q_we;
    assign coef_wdata = s_q.cwd;
    assign map_we     = s_q.m_we;
    assign map_wdata  = s_q.mwd;
    assign wr_addr    = s_q.waddr;
    assign rd_addr    = eff_addr;
    assign rd_data    = s_q.rdat;

    // R2: a coefficient strobe follows a load-code transfer
    assert_coef_after_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_i_we || coef_q_we) |-> $past(xfer_stb && xfer_code == LOAD_CODE));

    // R3: map and coefficient strobes never coincide
    assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({map_we, coef_i_we || coef_q_we}));

    // R8: no strobe after a write aimed at the FIFO or an unused code
    assert_no_bad_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !s_q.ctrl.rd_dir && (s_q.ctrl.tgt == TGT_FIFO || s_q.ctrl.tgt == TGT_NONE
            || s_q.ctrl.tgt == TGT_RSV6 || s_q.ctrl.tgt == TGT_RSV7))
        |=> !(coef_i_we || coef_q_we || map_we));

    // R11: other transfer codes leave the outputs quiet
    assert_code_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && xfer_code != LOAD_CODE && !cfg_we)
        |=> ($stable(rd_data) && !(coef_i_we || coef_q_we || map_we)));

endmodule

// File: tb/imc_top_tb.sv
module imc_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_data = '0;
    logic        xfer_stb = 1'b0;
    logic [7:0]  xfer_code = '0;
    logic [31:0] stage_data = '0;
    logic [7:0]  host_addr = '0;
    logic        coef_i_we, coef_q_we, map_we;
    logic [71:0] coef_wdata, coef_i_rdata, coef_q_rdata;
    logic [7:0]  map_wdata, wr_addr, rd_addr, map_rdata;
    logic [31:0] fifo_rdata, rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [71:0] ram_i(input logic [7:0] a);
        return {a ^ 8'h5A, 32'hC0DE_0000 | 32'(a), 32'hBEEF_0000 | 32'(a)};
    endfunction
    function automatic logic [71:0] ram_q(input logic [7:0] a);
        return {a ^ 8'h3C, 32'h0D0D_0000 | 32'(a), 32'h7777_0000 | 32'(a)};
    endfunction

    assign coef_i_rdata = ram_i(rd_addr);
    assign coef_q_rdata = ram_q(rd_addr);
    assign map_rdata    = rd_addr ^ 8'hA5;
    assign fifo_rdata   = 32'hF1F0_0000 | 32'(rd_addr);

    imc_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .xfer_stb(xfer_stb), .xfer_code(xfer_code), .stage_data(stage_data),
        .host_addr(host_addr), .coef_i_we(coef_i_we), .coef_q_we(coef_q_we),
        .coef_wdata(coef_wdata), .map_we(map_we), .map_wdata(map_wdata),
        .wr_addr(wr_addr), .rd_addr(rd_addr), .coef_i_rdata(coef_i_rdata),
        .coef_q_rdata(coef_q_rdata), .map_rdata(map_rdata),
        .fifo_rdata(fifo_rdata), .rd_data(rd_data)
    );

    task automatic check(input string req, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input bit auto_inc, input bit rd, input logic [2:0] tgt);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_data = {1'b0, auto_inc, rd, tgt, 2'b00};
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic xfer(input logic [31:0] val, input logic [7:0] code);
        @(negedge clk);
        xfer_stb   = 1'b1;
        xfer_code  = code;
        stage_data = val;
        @(negedge clk);
        xfer_stb   = 1'b0;
    endtask

    function automatic logic [2:0] strobes();
        return {coef_i_we, coef_q_we, map_we};
    endfunction

    task automatic t_reset();
        host_addr = 8'h00;
        check("R1", "strobes", 72'(strobes()), 72'd0);
        check("R1", "rd_data", 72'(rd_data), 72'd0);
        host_addr = 8'h2B;
        #1;
        check("R1", "manual addr", 72'(rd_addr), 72'h2B);
        host_addr = 8'h00;
    endtask

    task automatic wide_word(input logic [2:0] tgt, input logic [31:0] b,
                             input logic [7:0] exp_addr, input string req);
        xfer(b, 8'h0F);
        check(req, "no strobe slice0", 72'(strobes()), 72'd0);
        xfer(b ^ 32'h1111_1111, 8'h0F);
        check(req, "no strobe slice1", 72'(strobes()), 72'd0);
        xfer(b ^ 32'h2222_22A3, 8'h0F);
        check(req, "strobes slice2", 72'(strobes()), 72'({tgt[0], tgt[1], 1'b0}));
        check(req, "coef data", coef_wdata,
              {8'(b ^ 32'h2222_22A3), b ^ 32'h1111_1111, b});
        check(req, "coef addr", 72'(wr_addr), 72'(exp_addr));
        @(negedge clk);
        check(req, "one-cycle strobe", 72'(strobes()), 72'd0);
    endtask

    task automatic t_wide_write();
        cfg(1'b1, 1'b0, 3'b001);
        wide_word(3'b001, 32'h0123_4567, 8'd0, "R2");
        check("R6", "addr after word", 72'(rd_addr), 72'd1);
        cfg(1'b1, 1'b0, 3'b011);
        check("R7", "addr cleared", 72'(rd_addr), 72'd0);
        wide_word(3'b011, 32'h89AB_CDEF, 8'd0, "R3");
        cfg(1'b1, 1'b0, 3'b010);
        wide_word(3'b010, 32'h5555_AAAA, 8'd0, "R3");
    endtask

    task automatic t_coef_wrap();
        cfg(1'b1, 1'b0, 3'b001);
        for (int k = 0; k < 64; k++) begin
            xfer(32'(k), 8'h0F);
            xfer(32'(k), 8'h0F);
            xfer(32'(k), 8'h0F);
            if (k == 63) begin
                check("R6", "last coef addr", 72'(wr_addr), 72'd63);
                check("R6", "last coef strobe", 72'(coef_i_we), 72'd1);
            end
        end
        check("R6", "coef wrap", 72'(rd_addr), 72'd0);
    endtask

    task automatic t_map();
        int bad = 0;
        cfg(1'b1, 1'b0, 3'b100);
        for (int k = 0; k < 256; k++) begin
            xfer(32'hABCD_0000 | 32'(k ^ 8'h33), 8'h0F);
            if (!map_we || map_wdata !== 8'(k ^ 8'h33) || wr_addr !== 8'(k)) bad++;
        end
        check("R4", "map writes mismatching", 72'(bad), 72'd0);
        check("R6", "map wrap", 72'(rd_addr), 72'd0);
        xfer(32'h0, 8'h0F);
        cfg(1'b1, 1'b1, 3'b100);
        check("R7", "same target keeps addr", 72'(rd_addr), 72'd1);
    endtask

    task automatic t_manual();
        cfg(1'b0, 1'b0, 3'b100);
        host_addr = 8'h37;
        xfer(32'h0000_00E1, 8'h0F);
        check("R5", "manual write addr", 72'(wr_addr), 72'h37);
        check("R5", "manual write data", 72'(map_wdata), 72'hE1);
        host_addr = 8'h10;
        #1;
        check("R5", "manual rd_addr", 72'(rd_addr), 72'h10);
        host_addr = 8'h00;
    endtask

    task automatic t_blocked();
        cfg(1'b1, 1'b0, 3'b101);
        xfer(32'hDEAD_BEEF, 8'h0F);
        check("R8", "fifo write strobes", 72'(strobes()), 72'd0);
        check("R8", "fifo write addr", 72'(rd_addr), 72'd0);
        cfg(1'b1, 1'b0, 3'b110);
        xfer(32'hDEAD_BEEF, 8'h0F);
        check("R8", "unused write strobes", 72'(strobes()), 72'd0);
        check("R8", "unused write addr", 72'(rd_addr), 72'd0);
    endtask

    task automatic t_read();
        logic [71:0] w;
        cfg(1'b1, 1'b1, 3'b001);
        w = ram_i(8'd0);
        xfer(32'h0, 8'h0F);
        check("R9", "I slice0", 72'(rd_data), 72'(w[31:0]));
        xfer(32'h0, 8'h0F);
        check("R9", "I slice1", 72'(rd_data), 72'(w[63:32]));
        check("R9", "addr held mid-word", 72'(rd_addr), 72'd0);
        xfer(32'h0, 8'h0F);
        check("R9", "I slice2", 72'(rd_data), 72'(w[71:64]));
        check("R9", "addr after read word", 72'(rd_addr), 72'd1);
        cfg(1'b1, 1'b1, 3'b010);
        w = ram_q(8'd0);
        xfer(32'h0, 8'h0F);
        check("R9", "Q slice0", 72'(rd_data), 72'(w[31:0]));
        cfg(1'b1, 1'b1, 3'b100);
        xfer(32'h0, 8'h0F);
        check("R10", "map read", 72'(rd_data), 72'(8'h00 ^ 8'hA5));
        xfer(32'h0, 8'h0F);
        check("R10", "map read next", 72'(rd_data), 72'(8'h01 ^ 8'hA5));
        cfg(1'b1, 1'b1, 3'b101);
        xfer(32'h0, 8'h0F);
        check("R10", "fifo read", 72'(rd_data), 72'h00F1F0_0000);
        check("R10", "fifo addr step", 72'(rd_addr), 72'd1);
    endtask

    task automatic t_bad_code();
        logic [31:0] held;
        held = rd_data;
        xfer(32'h0, 8'h0C);
        check("R11", "read held", 72'(rd_data), 72'(held));
        check("R11", "read addr held", 72'(rd_addr), 72'd1);
        cfg(1'b1, 1'b0, 3'b100);
        xfer(32'h0000_0077, 8'h05);
        check("R11", "no map strobe", 72'(strobes()), 72'd0);
        check("R11", "write addr held", 72'(rd_addr), 72'd0);
    endtask

    task automatic t_restart();
        cfg(1'b1, 1'b0, 3'b001);
        xfer(32'hFFFF_FFFF, 8'h0F);
        cfg(1'b1, 1'b0, 3'b001);
        wide_word(3'b001, 32'h1357_9BDF, 8'd0, "R12");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_wide_write();
        t_coef_wrap();
        t_map();
        t_manual();
        t_blocked();
        t_read();
        t_bad_code();
        t_restart();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule